// File: doc/BRIEF.md
# Quick-Channel Parameter Store and Trigger Unit

This unit holds the descriptor memory of a DMA controller: a table of transfer slots, each eight 32-bit words wide, which software reads and writes over a simple register bus. Beside the table sits a small bank of quick channels. Each channel points at one slot and at one word inside that slot. A transfer starts without any start bit. When software writes the chosen word of the chosen slot, and that channel is enabled, the unit raises a transfer request for the slot.

Requests go to a transfer engine over a request/acknowledge/done handshake. When the engine reports a channel done, the unit reads that slot's option word. If the option word's completion-interrupt flag is set, the unit sets one bit of a 64-bit pending vector, indexed by the completion code held in the same word. Software clears pending bits by writing ones. A channel tracks a second trigger that arrives while its first is still queued or in flight, and software can read and clear these missed events.

Software usage: fill a slot, write the option word, map a channel to the slot, enable the channel, and then write the trigger word to launch the transfer. Poll the pending vector to see when the transfer has finished.

Top module: `qc_trigger_top`

## Requirements
- R1: Slot s, word w (s < 512, w < 8) is stored at byte address 0x4000 + 32*s + 4*w. A bus read returns the stored value on bus_rdata in the cycle after the read is presented.
- R2: Channel k (k < 8) has a map register at 0x200 + 4*k. The slot number sits in bits [13:5] and the word index in bits [4:2], and reading the register returns these fields. A map register whose two fields are both zero leaves the channel unbound, and an unbound channel never triggers.
- R3: A write to the mapped slot and word of a bound, enabled channel queues a request for that channel. A write to any other word, or a write while the channel is disabled, queues nothing. The queued bits read back at 0x1090 (bit k = channel k).
- R4: Writing ones to 0x108C sets channel enable bits, and writing ones to 0x1088 clears them. Reading either address returns the enable vector.
- R5: xfer_req is high whenever any channel is queued. xfer_chan is the lowest-numbered queued channel, and xfer_slot is that channel's mapped slot. On xfer_ack the channel leaves the queued state and becomes in flight, and the next queued channel is then presented.
- R6: A trigger on a channel that is already queued or in flight sets that channel's missed bit (readable at 0x310) and creates no second request. Writing ones to 0x314 clears missed bits.
- R7: Writing ones to 0x1094 cancels the queued requests of those channels.
- R8: When xfer_done is given with xfer_done_chan naming an in-flight channel, that channel becomes idle. If bit 20 of word 0 of the slot it was issued for is 1, the pending bit for code = bits [17:12] of that word is set. Codes 0-31 appear at bit code of 0x1068, and codes 32-63 at bit code-32 of 0x106C. A done for a channel that is not in flight has no effect.
- R9: Writing ones to 0x1070 clears low pending bits, and writing ones to 0x1074 clears high pending bits. If a set and a clear of the same bit fall in one cycle, the set wins.
- R10: After reset, all map registers, enables, queued, in-flight, missed and pending bits are zero, and xfer_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus operation present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| xfer_req | output | 1 | A channel has a queued transfer |
| xfer_chan | output | 3 | Channel being offered to the engine |
| xfer_slot | output | 9 | Slot of the offered channel |
| xfer_ack | input | 1 | Engine accepts the offered channel |
| xfer_done | input | 1 | Engine finished a transfer |
| xfer_done_chan | input | 3 | Channel whose transfer finished |

## Verification
A write, an acknowledge or a done acts at the clock edge that samples it. The resulting xfer_req, xfer_chan and xfer_slot are due in that same cycle after the edge. A pending bit set by a done is visible to any read issued afterwards. Read data lags the read by exactly one edge. The bench drives on the falling edge and steps a behavioural model at the rising edge. It compares the request outputs half a cycle later on every clock, and it compares bus_rdata only in the cycle after a read. Directed reads with literal expected values confirm each corner: a missed event in the queued and in-flight states, cancellation, unbinding, priority order, a done for an idle channel, and a set and clear of the same pending bit in one cycle.

// File: rtl/qc_pkg.sv
package qc_pkg;
    // register offsets (byte addresses)
    localparam logic [15:0] MAP_BASE   = 16'h0200;
    localparam logic [15:0] MISS_STAT  = 16'h0310;
    localparam logic [15:0] MISS_CLR   = 16'h0314;
    localparam logic [15:0] PEND_LO    = 16'h1068;
    localparam logic [15:0] PEND_HI    = 16'h106C;
    localparam logic [15:0] PCLR_LO    = 16'h1070;
    localparam logic [15:0] PCLR_HI    = 16'h1074;
    localparam logic [15:0] EN_CLR     = 16'h1088;
    localparam logic [15:0] EN_SET     = 16'h108C;
    localparam logic [15:0] QUEUE_STAT = 16'h1090;
    localparam logic [15:0] QUEUE_CLR  = 16'h1094;
    localparam logic [15:0] RAM_BASE   = 16'h4000;

    // field positions
    localparam int MAP_SLOT_LSB = 5;
    localparam int MAP_WORD_LSB = 2;
    localparam int OPT_IEN_BIT  = 20;
    localparam int OPT_CODE_LSB = 12;
    localparam int CODE_COUNT   = 64;
    localparam int HALF_W       = 32;
endpackage

// File: rtl/qc_param_ram.sv
module qc_param_ram #(
    parameter int DEPTH = 4096,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr_a,
    output logic [DW-1:0]            rdata_a,
    input  logic [$clog2(DEPTH)-1:0] raddr_b,
    output logic [DW-1:0]            rdata_b
);
    // Descriptor words carry no reset; software fills a slot before use.
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/qc_chan_ctrl.sv
module qc_chan_ctrl #(
    parameter int CHANS  = 8,
    parameter int SLOT_W = 9,
    parameter int WORD_W = 3,
    localparam int CW    = $clog2(CHANS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ram_we,
    input  logic [SLOT_W-1:0]             ram_slot,
    input  logic [WORD_W-1:0]             ram_word,
    input  logic                          map_we,
    input  logic [CW-1:0]                 map_chan,
    input  logic [SLOT_W-1:0]             map_slot_in,
    input  logic [WORD_W-1:0]             map_word_in,
    input  logic [CHANS-1:0]              en_set,
    input  logic [CHANS-1:0]              en_clr,
    input  logic [CHANS-1:0]              queue_clr,
    input  logic [CHANS-1:0]              miss_clr,
    input  logic                          xfer_ack,
    input  logic                          xfer_done,
    input  logic [CW-1:0]                 xfer_done_chan,
    output logic [CHANS-1:0][SLOT_W-1:0]  map_slot,
    output logic [CHANS-1:0][WORD_W-1:0]  map_word,
    output logic [CHANS-1:0]              en,
    output logic [CHANS-1:0]              queued,
    output logic [CHANS-1:0]              missed,
    output logic                          xfer_req,
    output logic [CW-1:0]                 xfer_chan,
    output logic [SLOT_W-1:0]             xfer_slot,
    output logic                          done_hit,
    output logic [SLOT_W-1:0]             done_slot
);
    typedef struct packed {
        logic [CHANS-1:0][SLOT_W-1:0] slot;
        logic [CHANS-1:0][WORD_W-1:0] word;
        logic [CHANS-1:0][SLOT_W-1:0] issued;
        logic [CHANS-1:0]             en;
        logic [CHANS-1:0]             queued;
        logic [CHANS-1:0]             active;
        logic [CHANS-1:0]             missed;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [CW-1:0] pick;
    logic          pick_found;

    always_comb begin
        st_d       = st_q;
        pick       = '0;
        pick_found = 1'b0;
        // lowest-numbered queued channel is offered first
        for (int k = 0; k < CHANS; k++) begin
            if (!pick_found && st_q.queued[k]) begin
                pick       = CW'(k);
                pick_found = 1'b1;
            end
        end
        // trigger detection against the bound word
        for (int k = 0; k < CHANS; k++) begin
            if (ram_we && st_q.en[k] && ((st_q.slot[k] != '0) || (st_q.word[k] != '0))
                && (st_q.slot[k] == ram_slot) && (st_q.word[k] == ram_word)) begin
                if (st_q.queued[k] || st_q.active[k]) st_d.missed[k] = 1'b1;
                else                                  st_d.queued[k] = 1'b1;
            end
        end
        if (map_we) begin
            st_d.slot[map_chan] = map_slot_in;
            st_d.word[map_chan] = map_word_in;
        end
        st_d.en     = (st_q.en | en_set) & ~en_clr;
        st_d.queued = st_d.queued & ~queue_clr;
        st_d.missed = st_d.missed & ~miss_clr;
        if (xfer_ack && pick_found) begin
            st_d.queued[pick] = 1'b0;
            st_d.active[pick] = 1'b1;
            st_d.issued[pick] = st_q.slot[pick];
        end
        if (xfer_done && st_q.active[xfer_done_chan]) begin
            st_d.active[xfer_done_chan] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_slot  = st_q.slot;
    assign map_word  = st_q.word;
    assign en        = st_q.en;
    assign queued    = st_q.queued;
    assign missed    = st_q.missed;
    assign xfer_req  = pick_found;
    assign xfer_chan = pick;
    assign xfer_slot = st_q.slot[pick];
    assign done_hit  = xfer_done && st_q.active[xfer_done_chan];
    assign done_slot = st_q.issued[xfer_done_chan];

    // R5: a channel is never queued and in flight at once
    a_r5_queue_active_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.queued & st_q.active) == '0);

    // R5: an accepted offer puts the offered channel in flight
    a_r5_ack_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && xfer_req) |=> st_q.active[$past(xfer_chan)]);

    // R3: a new queued bit only appears on a channel that was enabled
    a_r3_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.queued & ~$past(st_q.queued)) & ~$past(st_q.en)) == '0);

    // R6: a missed bit only rises on a channel that was busy
    a_r6_miss_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.missed & ~$past(st_q.missed)) & ~($past(st_q.queued) | $past(st_q.active))) == '0);

    // R8: a done retires the in-flight channel
    a_r8_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && st_q.active[xfer_done_chan]) |=> !st_q.active[$past(xfer_done_chan)]);
endmodule

// File: rtl/qc_pend_vec.sv
module qc_pend_vec #(
    parameter int CODES   = 64,
    localparam int CODE_W = $clog2(CODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [CODE_W-1:0] set_code,
    input  logic [CODES-1:0]  clr_mask,
    output logic [CODES-1:0]  pend
);
    typedef struct packed {
        logic [CODES-1:0] bits;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = st_q.bits & ~clr_mask;
        if (set_valid) st_d.bits[set_code] = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.bits;

    // R9: a set is never lost, even with a clear of the same bit
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> pend[$past(set_code)]);

    // R8: at most one pending bit rises per cycle
    a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend & ~$past(pend)) <= 1);
endmodule

// File: rtl/qc_trigger_top.sv
module qc_trigger_top
    import qc_pkg::*;
#(
    parameter int SLOTS     = 512,
    parameter int WORDS     = 8,
    parameter int CHANS     = 8,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int WORD_W   = $clog2(WORDS),
    localparam int CHAN_W   = $clog2(CHANS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [15:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              xfer_req,
    output logic [CHAN_W-1:0] xfer_chan,
    output logic [SLOT_W-1:0] xfer_slot,
    input  logic              xfer_ack,
    input  logic              xfer_done,
    input  logic [CHAN_W-1:0] xfer_done_chan
);
    localparam int IDX_W     = SLOT_W + WORD_W;
    localparam int DEPTH     = SLOTS * WORDS;
    localparam int RAM_BYTES = DEPTH * 4;
    localparam int CODE_W    = $clog2(CODE_COUNT);

    typedef struct packed {
        logic [31:0] data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    logic [15:0]       ram_off;
    logic              ram_hit, map_hit, wr, rdv, ram_we, map_we;
    logic [IDX_W-1:0]  ram_idx;
    logic [CHAN_W-1:0] map_ch;
    logic [CHANS-1:0]  en_set, en_clr, queue_clr, miss_clr;
    logic [CODE_COUNT-1:0] pend_clr;

    logic [CHANS-1:0][SLOT_W-1:0] map_slot;
    logic [CHANS-1:0][WORD_W-1:0] map_word;
    logic [CHANS-1:0] en, queued, missed;
    logic              done_hit;
    logic [SLOT_W-1:0] done_slot;
    logic [31:0]       ram_rdata, opt_word;
    logic [CODE_COUNT-1:0] pend;
    logic              pend_set;
    logic [CODE_W-1:0] pend_code;

    // address decode
    always_comb begin
        ram_off   = bus_addr - RAM_BASE;
        ram_hit   = (bus_addr >= RAM_BASE) && (32'(ram_off) < RAM_BYTES);
        ram_idx   = ram_off[IDX_W+1:2];
        map_hit   = (bus_addr >= MAP_BASE) && (32'(bus_addr) < 32'(MAP_BASE) + 4 * CHANS);
        map_ch    = bus_addr[CHAN_W+1:2];
        wr        = bus_valid && bus_write;
        rdv       = bus_valid && !bus_write;
        ram_we    = wr && ram_hit;
        map_we    = wr && map_hit;
        en_set    = (wr && bus_addr == EN_SET)    ? bus_wdata[CHANS-1:0] : '0;
        en_clr    = (wr && bus_addr == EN_CLR)    ? bus_wdata[CHANS-1:0] : '0;
        queue_clr = (wr && bus_addr == QUEUE_CLR) ? bus_wdata[CHANS-1:0] : '0;
        miss_clr  = (wr && bus_addr == MISS_CLR)  ? bus_wdata[CHANS-1:0] : '0;
        pend_clr  = '0;
        if (wr && bus_addr == PCLR_LO) pend_clr[HALF_W-1:0]          = bus_wdata;
        if (wr && bus_addr == PCLR_HI) pend_clr[CODE_COUNT-1:HALF_W] = bus_wdata;
    end

    qc_param_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_idx),
        .wdata   (bus_wdata),
        .raddr_a (ram_idx),
        .rdata_a (ram_rdata),
        .raddr_b ({done_slot, {WORD_W{1'b0}}}),
        .rdata_b (opt_word)
    );

    qc_chan_ctrl #(.CHANS(CHANS), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_chan (
        .clk            (clk),
        .rst_n          (rst_n),
        .ram_we         (ram_we),
        .ram_slot       (ram_idx[IDX_W-1:WORD_W]),
        .ram_word       (ram_idx[WORD_W-1:0]),
        .map_we         (map_we),
        .map_chan       (map_ch),
        .map_slot_in    (bus_wdata[MAP_SLOT_LSB +: SLOT_W]),
        .map_word_in    (bus_wdata[MAP_WORD_LSB +: WORD_W]),
        .en_set         (en_set),
        .en_clr         (en_clr),
        .queue_clr      (queue_clr),
        .miss_clr       (miss_clr),
        .xfer_ack       (xfer_ack),
        .xfer_done      (xfer_done),
        .xfer_done_chan (xfer_done_chan),
        .map_slot       (map_slot),
        .map_word       (map_word),
        .en             (en),
        .queued         (queued),
        .missed         (missed),
        .xfer_req       (xfer_req),
        .xfer_chan      (xfer_chan),
        .xfer_slot      (xfer_slot),
        .done_hit       (done_hit),
        .done_slot      (done_slot)
    );

    assign pend_set  = done_hit && opt_word[OPT_IEN_BIT];
    assign pend_code = opt_word[OPT_CODE_LSB +: CODE_W];

    qc_pend_vec #(.CODES(CODE_COUNT)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (pend_set),
        .set_code  (pend_code),
        .clr_mask  (pend_clr),
        .pend      (pend)
    );

    // read mux, registered one cycle
    always_comb begin
        rd_d = rd_q;
        if (rdv) begin
            rd_d.data = '0;
            if (ram_hit) begin
                rd_d.data = ram_rdata;
            end else if (map_hit) begin
                rd_d.data[MAP_SLOT_LSB +: SLOT_W] = map_slot[map_ch];
                rd_d.data[MAP_WORD_LSB +: WORD_W] = map_word[map_ch];
            end else begin
                case (bus_addr)
                    EN_SET, EN_CLR: rd_d.data = 32'(en);
                    QUEUE_STAT:     rd_d.data = 32'(queued);
                    MISS_STAT:      rd_d.data = 32'(missed);
                    PEND_LO:        rd_d.data = pend[HALF_W-1:0];
                    PEND_HI:        rd_d.data = pend[CODE_COUNT-1:HALF_W];
                    default:        rd_d.data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.data;

    logic unused_bits;
    assign unused_bits = ^{opt_word[31:OPT_IEN_BIT+1], opt_word[OPT_IEN_BIT-1:OPT_CODE_LSB+CODE_W],
                           opt_word[OPT_CODE_LSB-1:0], ram_off[1:0], ram_off[15:IDX_W+2]};

    // R1: read data follows a read by one cycle and is otherwise held
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

    // R9: a clear with no done removes the low pending bits written
    a_r9_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == PCLR_LO && !xfer_done)
        |=> (pend[HALF_W-1:0] & $past(bus_wdata)) == '0);
endmodule

// File: tb/qc_trigger_top_tb.sv
module qc_trigger_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        b_valid, b_write, x_ack, x_done;
    logic [15:0] b_addr;
    logic [31:0] b_wdata;
    logic [2:0]  x_done_chan;
    logic [31:0] bus_rdata;
    logic        xfer_req;
    logic [2:0]  xfer_chan;
    logic [8:0]  xfer_slot;

    always #5 clk = ~clk;

    qc_trigger_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(b_valid), .bus_write(b_write),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(bus_rdata),
        .xfer_req(xfer_req), .xfer_chan(xfer_chan), .xfer_slot(xfer_slot),
        .xfer_ack(x_ack), .xfer_done(x_done), .xfer_done_chan(x_done_chan)
    );

    int errors = 0;
    int checks = 0;

    // behavioural reference model
    logic [31:0] m_mem [int];
    logic [8:0]  m_slot [8];
    logic [2:0]  m_word [8];
    logic [8:0]  m_iss  [8];
    logic [7:0]  m_en, m_q, m_act, m_miss;
    logic [63:0] m_pend;
    logic [31:0] m_rd;
    bit          m_rd_due;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [15:0] a);
        int idx;
        if (a >= 16'h4000) begin
            idx = int'(a - 16'h4000) >> 2;
            return m_mem.exists(idx) ? m_mem[idx] : 32'h0;
        end
        if (a >= 16'h0200 && a < 16'h0220) begin
            idx = int'(a - 16'h0200) >> 2;
            return (32'(m_slot[idx]) << 5) | (32'(m_word[idx]) << 2);
        end
        case (a)
            16'h1088, 16'h108C: return 32'(m_en);
            16'h1090:           return 32'(m_q);
            16'h0310:           return 32'(m_miss);
            16'h1068:           return m_pend[31:0];
            16'h106C:           return m_pend[63:32];
            default:            return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_slot[k] = '0; m_word[k] = '0; m_iss[k] = '0;
        end
        m_en = '0; m_q = '0; m_act = '0; m_miss = '0; m_pend = '0; m_rd_due = 0;
    endtask

    task automatic model_step();
        logic [7:0] oq, oa, oen;
        logic       set_v;
        int         set_c, idx;
        logic [31:0] opt;
        oq = m_q; oa = m_act; oen = m_en; set_v = 0; set_c = 0;
        m_rd_due = 0;
        if (b_valid && !b_write) begin
            m_rd = m_read(b_addr);
            m_rd_due = 1;
        end
        if (x_ack && oq != 0) begin
            for (int c = 0; c < 8; c++) begin
                if (oq[c]) begin
                    m_q[c] = 0; m_act[c] = 1; m_iss[c] = m_slot[c];
                    break;
                end
            end
        end
        if (x_done && oa[x_done_chan]) begin
            m_act[x_done_chan] = 0;
            idx = int'(m_iss[x_done_chan]) * 8;
            opt = m_mem.exists(idx) ? m_mem[idx] : 32'h0;
            if (opt[20]) begin set_v = 1; set_c = int'(opt[17:12]); end
        end
        if (b_valid && b_write) begin
            if (b_addr >= 16'h4000) begin
                idx = int'(b_addr - 16'h4000) >> 2;
                m_mem[idx] = b_wdata;
                for (int k = 0; k < 8; k++) begin
                    if ((m_slot[k] != 0 || m_word[k] != 0) && oen[k]
                        && int'(m_slot[k]) == idx / 8 && int'(m_word[k]) == idx % 8) begin
                        if (oq[k] || oa[k]) m_miss[k] = 1;
                        else                m_q[k] = 1;
                    end
                end
            end else if (b_addr >= 16'h0200 && b_addr < 16'h0220) begin
                idx = int'(b_addr - 16'h0200) >> 2;
                m_slot[idx] = b_wdata[13:5];
                m_word[idx] = b_wdata[4:2];
            end else begin
                case (b_addr)
                    16'h108C: m_en = m_en | b_wdata[7:0];
                    16'h1088: m_en = m_en & ~b_wdata[7:0];
                    16'h1094: m_q = m_q & ~b_wdata[7:0];
                    16'h0314: m_miss = m_miss & ~b_wdata[7:0];
                    16'h1070: m_pend[31:0] = m_pend[31:0] & ~b_wdata;
                    16'h1074: m_pend[63:32] = m_pend[63:32] & ~b_wdata;
                    default: ;
                endcase
            end
        end
        if (set_v) m_pend[set_c] = 1'b1;
    endtask

    task automatic compare_cycle();
        chk("R5 xfer_req vs model", 64'(xfer_req), 64'(m_q != 0));
        if (m_q != 0) begin
            int c;
            for (c = 0; c < 8; c++) if (m_q[c]) break;
            chk("R5 xfer_chan vs model", 64'(xfer_chan), 64'(c));
            chk("R5 xfer_slot vs model", 64'(xfer_slot), 64'(m_slot[c]));
        end
        if (m_rd_due) chk("R1 bus_rdata vs model", 64'(bus_rdata), 64'(m_rd));
    endtask

    // one clock: inputs set now (falling edge), model steps at rising edge
    task automatic op(bit v, bit w, logic [15:0] a, logic [31:0] d,
                      bit ack, bit done, logic [2:0] dc);
        b_valid = v; b_write = w; b_addr = a; b_wdata = d;
        x_ack = ack; x_done = done; x_done_chan = dc;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_cycle();
        b_valid = 0; b_write = 0; b_addr = '0; b_wdata = '0;
        x_ack = 0; x_done = 0; x_done_chan = '0;
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        op(1, 1, a, d, 0, 0, 3'd0);
    endtask

    task automatic rd_exp(logic [15:0] a, logic [31:0] exp, string tag);
        op(1, 0, a, 32'h0, 0, 0, 3'd0);
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic ack1();
        op(0, 0, 16'h0, 32'h0, 1, 0, 3'd0);
    endtask

    task automatic done1(logic [2:0] c);
        op(0, 0, 16'h0, 32'h0, 0, 1, c);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R5 actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0;
        b_valid = 0; b_write = 0; b_addr = '0; b_wdata = '0;
        x_ack = 0; x_done = 0; x_done_chan = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10: reset state
        chk("R10 xfer_req after reset", 64'(xfer_req), 64'd0);
        rd_exp(16'h108C, 32'h0, "R10 enables after reset");
        rd_exp(16'h1068, 32'h0, "R10 pending low after reset");
        rd_exp(16'h106C, 32'h0, "R10 pending high after reset");
        rd_exp(16'h021C, 32'h0, "R10 map 7 after reset");
        rd_exp(16'h0310, 32'h0, "R10 missed after reset");

        // R1: slot storage at both ends of the table
        wr(16'h4000, 32'h1234_5678);
        wr(16'h7FFC, 32'hDEAD_BEEF);
        rd_exp(16'h4000, 32'h1234_5678, "R1 slot0 word0");
        rd_exp(16'h7FFC, 32'hDEAD_BEEF, "R1 slot511 word7");

        // R2: map channel 2 to slot 5 word 3
        wr(16'h0208, 32'h0000_00AC);
        rd_exp(16'h0208, 32'h0000_00AC, "R2 map readback");
        wr(16'h40A0, 32'h0012_8000);   // option: irq enable, code 40

        // R4: enable set, read at both addresses
        wr(16'h108C, 32'h4);
        rd_exp(16'h1088, 32'h4, "R4 enable via clear address");
        rd_exp(16'h108C, 32'h4, "R4 enable via set address");

        // R3: other word of the slot does not trigger
        wr(16'h40A8, 32'h55);
        rd_exp(16'h1090, 32'h0, "R3 non-trigger word");
        // R3: trigger word queues channel 2
        wr(16'h40AC, 32'h66);
        chk("R5 offered channel", 64'(xfer_chan), 64'd2);
        chk("R5 offered slot", 64'(xfer_slot), 64'd5);
        rd_exp(16'h1090, 32'h4, "R3 trigger queued");

        // R6: second trigger while queued
        wr(16'h40AC, 32'h67);
        rd_exp(16'h0310, 32'h4, "R6 missed while queued");
        rd_exp(16'h1090, 32'h4, "R6 still one request");

        ack1();
        chk("R5 req low after ack", 64'(xfer_req), 64'd0);
        rd_exp(16'h1090, 32'h0, "R5 queue empty after ack");
        wr(16'h0314, 32'h4);
        rd_exp(16'h0310, 32'h0, "R6 missed cleared");
        wr(16'h40AC, 32'h68);
        rd_exp(16'h0310, 32'h4, "R6 missed while in flight");
        chk("R6 no new request", 64'(xfer_req), 64'd0);
        wr(16'h0314, 32'h4);

        // R8: done sets high pending bit 40-32=8
        done1(3'd2);
        rd_exp(16'h106C, 32'h100, "R8 pending high bit");
        rd_exp(16'h1068, 32'h0, "R8 pending low untouched");
        // R9: clear high half
        wr(16'h1074, 32'h100);
        rd_exp(16'h106C, 32'h0, "R9 clear high");
        // R8: done for idle channel ignored
        done1(3'd2);
        rd_exp(16'h106C, 32'h0, "R8 done on idle ignored");

        // R4: disabled channel does not trigger
        wr(16'h1088, 32'h4);
        rd_exp(16'h108C, 32'h0, "R4 enable cleared");
        wr(16'h40AC, 32'h69);
        rd_exp(16'h1090, 32'h0, "R4 disabled no trigger");

        // R2: unbind by writing zero
        wr(16'h020C, 32'h0000_00E4);
        wr(16'h108C, 32'h8);
        wr(16'h020C, 32'h0);
        rd_exp(16'h020C, 32'h0, "R2 unbound readback");
        wr(16'h40E4, 32'h1);
        rd_exp(16'h1090, 32'h0, "R2 unbound no trigger");

        // R5: priority between channels 1 and 4
        wr(16'h0204, 32'h0000_0130);   // ch1 -> slot 9 word 4
        wr(16'h0210, 32'h0000_0184);   // ch4 -> slot 12 word 1
        wr(16'h4120, 32'h0010_3000);   // slot 9 option: irq, code 3
        wr(16'h4180, 32'h0000_7000);   // slot 12 option: no irq, code 7
        wr(16'h108C, 32'h12);
        wr(16'h4184, 32'h2);
        chk("R5 single queued channel", 64'(xfer_chan), 64'd4);
        wr(16'h4130, 32'h3);
        chk("R5 lowest channel first", 64'(xfer_chan), 64'd1);
        chk("R5 slot of lowest", 64'(xfer_slot), 64'd9);
        ack1();
        chk("R5 next channel offered", 64'(xfer_chan), 64'd4);
        ack1();
        done1(3'd4);
        rd_exp(16'h1068, 32'h0, "R8 option without irq flag");
        done1(3'd1);
        rd_exp(16'h1068, 32'h8, "R8 pending low code 3");

        // R9: set and clear of the same bit in one cycle
        wr(16'h4130, 32'h4);
        ack1();
        op(1, 1, 16'h1070, 32'h8, 0, 1, 3'd1);
        rd_exp(16'h1068, 32'h8, "R9 set wins");
        wr(16'h1070, 32'h8);
        rd_exp(16'h1068, 32'h0, "R9 clear low");

        // R7: cancel a queued request
        wr(16'h0218, 32'h0000_029C);   // ch6 -> slot 20 word 7
        wr(16'h108C, 32'h40);
        wr(16'h429C, 32'h5);
        rd_exp(16'h1090, 32'h40, "R7 queued before cancel");
        wr(16'h1094, 32'h40);
        chk("R7 req low after cancel", 64'(xfer_req), 64'd0);
        rd_exp(16'h1090, 32'h0, "R7 queue cleared");

        repeat (3) op(0, 0, 16'h0, 32'h0, 0, 0, 3'd0);
        summary();
        $finish;
    end
endmodule